// File: doc/BRIEF.md
# Raster Display Controller Register Bank

This block is the software-visible configuration store of a raster display controller. A host reaches it over a plain 32-bit, word-addressed bus with separate write and read strobes. It holds four panel timing words, the frame base addresses of an upper and a lower panel, a control word and an interrupt mask. It also keeps a raw interrupt status that hardware events set and software clears. From these it drives decoded settings straight to the pixel pipeline: active pixels per line, active line count, the colour depth code, the colour order and byte/pixel ordering flags, and a qualified display enable.

Read data is registered and appears the cycle after the read strobe. The block also returns two current-address values supplied by the fetch engine and a fixed set of identification bytes. A layout strap moves the control word and the interrupt mask to each other's offsets, so that two board variants can share one register map. Accesses to unmapped offsets return zero and raise a one-cycle error pulse. Every write to a writable register raises a one-cycle change notice, which tells the pipeline to reload its settings.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset all stored registers, the raw status and the mask are zero; `irq`, `display_en`, `bus_err`, `cfg_changed` and `bus_rdata` are 0; `pixels_per_line` is 16 and `active_lines` is 1.
- R2: Word offsets 0–3 (timing words 0–3), 4 (upper base) and 5 (lower base) store all 32 written bits. A read returns the stored word on `bus_rdata` in the cycle after the read strobe. `upper_base` and `lower_base` show the stored bases.
- R3: `pixels_per_line` equals ((timing0 AND 0xFC) + 4) × 4, and no other bit of timing0 affects it.
- R4: `active_lines` equals timing1 bits [9:0] plus 1.
- R5: Control bits [3:1] drive `bpp_code`; bit 8 drives `bgr_order`; bit 9 drives `be_bytes`; bit 10 drives `be_pixels`. `display_en` is high only when control bit 0 and control bit 11 are both 1.
- R6: With `layout_swap` low, the interrupt mask is at offset 6 and the control word at offset 7. With it high, the two exchange offsets for both reads and writes.
- R7: A 1 on `irq_event[i]` sets raw status bit i. Offset 8 reads the raw status and offset 9 reads raw AND mask. The mask keeps only its low N_IRQ bits, and the bits above them read as 0. `irq` is the OR of the masked status bits.
- R8: A write to offset 10 clears each raw status bit written as 1 and leaves the others unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set. Offset 10 reads as zero.
- R9: Offsets 11 and 12 read the `upper_cur_addr` and `lower_cur_addr` inputs.
- R10: Word offsets 0x3F8 to 0x3FF (byte offsets 0xFE0–0xFFC) read, in order, 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0], with zeros above.
- R11: Offsets 13 to 0x3F7 are unmapped. Reads of them return 0 and writes to them change no register. Each such access raises `bus_err` for exactly the one cycle after it.
- R12: A write to offsets 0–7 or 10 raises `cfg_changed` for exactly the one cycle after it. A write to a read-only offset (8, 9, 11, 12) changes nothing and raises neither `cfg_changed` nor `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW (10) | Word offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| layout_swap | input | 1 | Exchanges the control and mask offsets |
| irq_event | input | N_IRQ (5) | Per-source status set pulses |
| upper_cur_addr | input | DW (32) | Upper panel current address for readback |
| lower_cur_addr | input | DW (32) | Lower panel current address for readback |
| irq | output | 1 | OR of masked status |
| cfg_changed | output | 1 | One-cycle pulse after a register write |
| upper_base | output | DW (32) | Upper panel frame base |
| lower_base | output | DW (32) | Lower panel frame base |
| pixels_per_line | output | 11 | Decoded active pixels per line |
| active_lines | output | 11 | Decoded active line count |
| bpp_code | output | 3 | Colour depth code |
| bgr_order | output | 1 | Blue/red swap |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order within bytes |
| display_en | output | 1 | Enable qualified by power |

## Verification
A corrupted timing or control register shows at the ports in the cycle after the write that should have set it, because the decoded geometry and flags follow the stored words with no further delay. The bench sweeps every timing0 field value, the whole line-count range and every combination of control flags and depth code. A wrong offset decode, for example one that ignores the strap or aliases an unmapped offset onto a real register, shows as a wrong read word one cycle after the read strobe, or as a missing error pulse. The full unmapped range is swept, and the registers are read back after writes to unmapped offsets. A status bit lost to a simultaneous clear shows as `irq` low on the next cycle and as a zero in the raw status readback.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  localparam int PPL_W  = 11;
  localparam int LINE_W = 11;

  typedef enum logic [3:0] {
    SEL_TIM   = 4'd0,
    SEL_UPB   = 4'd1,
    SEL_LPB   = 4'd2,
    SEL_MASK  = 4'd3,
    SEL_CTRL  = 4'd4,
    SEL_RAW   = 4'd5,
    SEL_MSTAT = 4'd6,
    SEL_CLR   = 4'd7,
    SEL_UPCUR = 4'd8,
    SEL_LPCUR = 4'd9,
    SEL_ID    = 4'd10,
    SEL_NONE  = 4'd11
  } reg_sel_e;

  // Identification byte for slot idx of the top eight words.
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h10;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_addr_decode.sv
module lcdc_addr_decode
  import lcdc_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr,
  input  logic          swap,
  output reg_sel_e      sel,
  output logic [1:0]    tim_idx,
  output logic [2:0]    id_idx
);

  localparam logic [AW-1:0] ID_FIRST = AW'((1 << AW) - 8);

  always_comb begin
    tim_idx = addr[1:0];
    id_idx  = addr[2:0];
    sel     = SEL_NONE;
    if (addr >= ID_FIRST) begin
      sel = SEL_ID;
    end else if (addr < AW'(4)) begin
      sel = SEL_TIM;
    end else if (addr == AW'(4)) begin
      sel = SEL_UPB;
    end else if (addr == AW'(5)) begin
      sel = SEL_LPB;
    end else if (addr == AW'(6)) begin
      sel = swap ? SEL_CTRL : SEL_MASK;
    end else if (addr == AW'(7)) begin
      sel = swap ? SEL_MASK : SEL_CTRL;
    end else if (addr == AW'(8)) begin
      sel = SEL_RAW;
    end else if (addr == AW'(9)) begin
      sel = SEL_MSTAT;
    end else if (addr == AW'(10)) begin
      sel = SEL_CLR;
    end else if (addr == AW'(11)) begin
      sel = SEL_UPCUR;
    end else if (addr == AW'(12)) begin
      sel = SEL_LPCUR;
    end
  end

endmodule

// File: rtl/lcdc_geom_decode.sv
module lcdc_geom_decode
  import lcdc_pkg::*;
(
  input  logic [5:0]        ppl_field,
  input  logic [9:0]        lines_field,
  output logic [PPL_W-1:0]  pixels_per_line,
  output logic [LINE_W-1:0] active_lines
);

  logic [PPL_W-3:0] ppl_quads;

  always_comb begin
    ppl_quads       = {1'b0, ppl_field, 2'b00} + (PPL_W-2)'(4);
    pixels_per_line = {ppl_quads, 2'b00};
    active_lines    = {1'b0, lines_field} + LINE_W'(1);
  end

endmodule

// File: rtl/lcdc_irq_status.sv
module lcdc_irq_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic         irq
);

  logic [N-1:0] raw_d;
  logic [N-1:0] mask_d;

  always_comb begin
    raw_d = raw;
    if (clr_en) raw_d = raw_d & ~clr_bits;
    raw_d  = raw_d | evt;
    mask_d = mask_we ? mask_wdata : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw  <= raw_d;
      mask <= mask_d;
    end
  end

  assign irq = |(raw & mask);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((raw & $past(evt)) == $past(evt)));

  p_clear_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(|(clr_bits & evt))) |=> ((raw & $past(clr_bits)) == '0));

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt & mask)) && !mask_we) |=> irq);

endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
  import lcdc_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int N_IRQ = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  input  logic              layout_swap,
  input  logic [N_IRQ-1:0]  irq_event,
  input  logic [DW-1:0]     upper_cur_addr,
  input  logic [DW-1:0]     lower_cur_addr,
  output logic              irq,
  output logic              cfg_changed,
  output logic [DW-1:0]     upper_base,
  output logic [DW-1:0]     lower_base,
  output logic [PPL_W-1:0]  pixels_per_line,
  output logic [LINE_W-1:0] active_lines,
  output logic [2:0]        bpp_code,
  output logic              bgr_order,
  output logic              be_bytes,
  output logic              be_pixels,
  output logic              display_en
);

  localparam int N_TIM = 4;
  localparam int EN_BIT = 0;
  localparam int PWR_BIT = 11;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  reg_sel_e   sel;
  logic [1:0] tim_idx;
  logic [2:0] id_idx;

  lcdc_addr_decode #(.AW(AW)) u_dec (
    .addr    (bus_addr),
    .swap    (layout_swap),
    .sel     (sel),
    .tim_idx (tim_idx),
    .id_idx  (id_idx)
  );

  logic [DW-1:0]    tim_q [N_TIM];
  logic [DW-1:0]    upb_q, lpb_q, ctrl_q;
  logic [N_TIM-1:0] tim_we;
  logic             upb_we, lpb_we, ctrl_we, mask_we, clr_en;
  logic             writable, unmapped;
  logic [DW-1:0]    rdata_d;
  logic             err_d, cfg_d;
  logic [N_IRQ-1:0] raw, mask;

  // Next-state and strobe decode
  always_comb begin
    tim_we   = '0;
    upb_we   = bus_wr && (sel == SEL_UPB);
    lpb_we   = bus_wr && (sel == SEL_LPB);
    ctrl_we  = bus_wr && (sel == SEL_CTRL);
    mask_we  = bus_wr && (sel == SEL_MASK);
    clr_en   = bus_wr && (sel == SEL_CLR);
    if (bus_wr && (sel == SEL_TIM)) tim_we[tim_idx] = 1'b1;
    writable = (sel == SEL_TIM) || (sel == SEL_UPB) || (sel == SEL_LPB) ||
               (sel == SEL_MASK) || (sel == SEL_CTRL) || (sel == SEL_CLR);
    unmapped = (sel == SEL_NONE);
    err_d    = (bus_wr || bus_rd) && unmapped;
    cfg_d    = bus_wr && writable;
    case (sel)
      SEL_TIM:   rdata_d = tim_q[tim_idx];
      SEL_UPB:   rdata_d = upb_q;
      SEL_LPB:   rdata_d = lpb_q;
      SEL_MASK:  rdata_d = DW'(mask);
      SEL_CTRL:  rdata_d = ctrl_q;
      SEL_RAW:   rdata_d = DW'(raw);
      SEL_MSTAT: rdata_d = DW'(raw & mask);
      SEL_UPCUR: rdata_d = upper_cur_addr;
      SEL_LPCUR: rdata_d = lower_cur_addr;
      SEL_ID:    rdata_d = DW'(id_byte(id_idx));
      default:   rdata_d = '0;
    endcase
  end

  // Registers, each with its own clock enable
  for (genvar g = 0; g < N_TIM; g++) begin : g_tim
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)    tim_q[g] <= '0;
      else if (tim_we[g]) tim_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      upb_q  <= '0;
      lpb_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (upb_we)  upb_q  <= bus_wdata;
      if (lpb_we)  lpb_q  <= bus_wdata;
      if (ctrl_we) ctrl_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_rdata   <= '0;
      bus_err     <= 1'b0;
      cfg_changed <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rdata_d;
      bus_err     <= err_d;
      cfg_changed <= cfg_d;
    end
  end

  lcdc_irq_status #(.N(N_IRQ)) u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .evt        (irq_event),
    .clr_en     (clr_en),
    .clr_bits   (bus_wdata[N_IRQ-1:0]),
    .mask_we    (mask_we),
    .mask_wdata (bus_wdata[N_IRQ-1:0]),
    .raw        (raw),
    .mask       (mask),
    .irq        (irq)
  );

  lcdc_geom_decode u_geom (
    .ppl_field       (tim_q[0][7:2]),
    .lines_field     (tim_q[1][9:0]),
    .pixels_per_line (pixels_per_line),
    .active_lines    (active_lines)
  );

  assign upper_base = upb_q;
  assign lower_base = lpb_q;
  assign bpp_code   = ctrl_q[3:1];
  assign bgr_order  = ctrl_q[8];
  assign be_bytes   = ctrl_q[9];
  assign be_pixels  = ctrl_q[10];
  assign display_en = ctrl_q[EN_BIT] && ctrl_q[PWR_BIT];

  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((bus_wr || bus_rd) && (sel == SEL_NONE)) |=> bus_err);

  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_wr || bus_rd) |=> !bus_err);

  p_cfg_quiet_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_wr |=> !cfg_changed);

  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_we |=> $stable(bpp_code) && $stable(display_en));

endmodule

// File: tb/tb_lcdc_regbank.sv
module tb_lcdc_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, irq, cfg_changed;
  logic        layout_swap = 1'b0;
  logic [4:0]  irq_event = '0;
  logic [31:0] upper_cur_addr = '0, lower_cur_addr = '0;
  logic [31:0] upper_base, lower_base;
  logic [10:0] pixels_per_line, active_lines;
  logic [2:0]  bpp_code;
  logic        bgr_order, be_bytes, be_pixels, display_en;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lcdc_regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .layout_swap(layout_swap), .irq_event(irq_event),
    .upper_cur_addr(upper_cur_addr), .lower_cur_addr(lower_cur_addr),
    .irq(irq), .cfg_changed(cfg_changed), .upper_base(upper_base),
    .lower_base(lower_base), .pixels_per_line(pixels_per_line),
    .active_lines(active_lines), .bpp_code(bpp_code), .bgr_order(bgr_order),
    .be_bytes(be_bytes), .be_pixels(be_pixels), .display_en(display_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 10'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 10'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [4:0] e);
    @(negedge clk);
    irq_event = e;
    @(negedge clk);
    irq_event = '0;
  endtask

  function automatic logic [7:0] exp_id(input int i);
    logic [7:0] t [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] saved [8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ppl", 32'(pixels_per_line), 32'd16);
    chk("R1 lines", 32'(active_lines), 32'd1);
    chk("R1 outs", {26'd0, irq, display_en, bus_err, cfg_changed, bgr_order, be_bytes}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    for (int a = 0; a <= 10; a++) begin
      rd(a, v); chk("R1 readback", v, 32'd0);
    end

    // R2 storage of timing and base words
    for (int a = 0; a < 6; a++) begin
      wr(a, 32'hA5C3_0000 ^ (32'h1111_1111 * (a + 1)));
    end
    for (int a = 0; a < 6; a++) begin
      rd(a, v); chk("R2 readback", v, 32'hA5C3_0000 ^ (32'h1111_1111 * (a + 1)));
    end
    chk("R2 upper_base", upper_base, 32'hA5C3_0000 ^ 32'h5555_5555);
    chk("R2 lower_base", lower_base, 32'hA5C3_0000 ^ 32'h6666_6666);

    // R3 pixels per line sweep over the whole low byte, noise above
    for (int t = 0; t < 256; t++) begin
      wr(0, 32'(t) | 32'hFFFF_FF00);
      chk("R3 ppl", 32'(pixels_per_line), ((t & 32'hFC) + 4) * 4);
    end

    // R4 line count sweep
    for (int n = 0; n < 1024; n += 7) begin
      wr(1, 32'(n) | 32'hFFFF_FC00);
      chk("R4 lines", 32'(active_lines), 32'(n) + 1);
    end
    wr(1, 32'h0000_03FF);
    chk("R4 lines max", 32'(active_lines), 32'd1024);

    // R5 control fields, all depth codes and flag combinations
    layout_swap = 1'b0;
    for (int b = 0; b < 8; b++) begin
      for (int f = 0; f < 32; f++) begin
        v = 32'h5000_0000 | 32'(f & 1) | 32'(b << 1) | 32'(((f >> 1) & 1) << 8) |
            32'(((f >> 2) & 1) << 9) | 32'(((f >> 3) & 1) << 10) | 32'(((f >> 4) & 1) << 11);
        wr(7, v);
        chk("R5 fields", {25'd0, bpp_code, bgr_order, be_bytes, be_pixels, display_en},
            {25'd0, 3'(b), 1'(f >> 1), 1'(f >> 2), 1'(f >> 3), 1'((f & 1) & (f >> 4))});
      end
    end

    // R6 strap exchanges control and mask offsets
    layout_swap = 1'b1;
    wr(6, 32'h0000_0805 | 32'h0000_0100);
    wr(7, 32'h0000_001F);
    chk("R6 ctrl via 6", {28'd0, bpp_code, display_en}, {28'd0, 3'd2, 1'b1});
    rd(6, v); chk("R6 read 6 swapped", v, 32'h0000_0905);
    rd(7, v); chk("R6 read 7 swapped", v, 32'h0000_001F);
    layout_swap = 1'b0;
    rd(7, v); chk("R6 read 7 normal", v, 32'h0000_0905);
    rd(6, v); chk("R6 read 6 normal", v, 32'h0000_001F);

    // R7 events, raw and masked status, irq
    wr(6, 32'hFFFF_FFE0);
    rd(6, v); chk("R7 mask width", v, 32'd0);
    pulse_evt(5'b00100);
    chk("R7 irq masked off", 32'(irq), 32'd0);
    rd(8, v); chk("R7 raw", v, 32'h4);
    rd(9, v); chk("R7 masked zero", v, 32'h0);
    wr(6, 32'h0000_0004);
    chk("R7 irq on", 32'(irq), 32'd1);
    rd(9, v); chk("R7 masked", v, 32'h4);

    // R8 write-one-to-clear and set priority
    wr(10, 32'h0000_0004);
    chk("R8 irq cleared", 32'(irq), 32'd0);
    rd(8, v); chk("R8 raw cleared", v, 32'h0);
    pulse_evt(5'b01001);
    wr(10, 32'h0000_0002);
    rd(8, v); chk("R8 other bits kept", v, 32'h9);
    wr(10, 32'h0000_001F);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 10'd10; bus_wdata = 32'h2; irq_event = 5'b00010;
    @(negedge clk);
    bus_wr = 1'b0; irq_event = '0;
    rd(8, v); chk("R8 set wins", v, 32'h2);
    rd(10, v); chk("R8 clear reads zero", v, 32'h0);
    wr(10, 32'h0000_001F);

    // R9 current address readbacks
    upper_cur_addr = 32'h1234_5678; lower_cur_addr = 32'h9ABC_DEF0;
    rd(11, v); chk("R9 upper cur", v, 32'h1234_5678);
    rd(12, v); chk("R9 lower cur", v, 32'h9ABC_DEF0);

    // R10 identification bytes
    for (int i = 0; i < 8; i++) begin
      rd(10'h3F8 + i, v); chk("R10 id", v, 32'(exp_id(i)));
      chk("R11 no err on id", 32'(bus_err), 32'd0);
    end

    // R11 unmapped range: reads zero with error pulse
    for (int a = 13; a < 10'h3F8; a++) begin
      rd(a, v);
      chk("R11 read zero", v, 32'd0);
      chk("R11 err", 32'(bus_err), 32'd1);
    end
    @(negedge clk);
    chk("R11 err one cycle", 32'(bus_err), 32'd0);
    for (int a = 0; a < 8; a++) rd(a, saved[a]);
    for (int a = 13; a < 10'h3F8; a += 37) begin
      wr(a, 32'hDEAD_BEEF);
      chk("R11 write err", 32'(bus_err), 32'd1);
      chk("R12 no cfg on unmapped", 32'(cfg_changed), 32'd0);
    end
    for (int a = 0; a < 8; a++) begin
      rd(a, v); chk("R11 regs unchanged", v, saved[a]);
    end

    // R12 change notice
    wr(2, 32'h0000_0042);
    chk("R12 cfg pulse", 32'(cfg_changed), 32'd1);
    @(negedge clk);
    chk("R12 cfg one cycle", 32'(cfg_changed), 32'd0);
    wr(10, 32'h0);
    chk("R12 cfg on clear", 32'(cfg_changed), 32'd1);
    wr(8, 32'hFFFF_FFFF);
    chk("R12 read-only no cfg", 32'(cfg_changed), 32'd0);
    chk("R12 read-only no err", 32'(bus_err), 32'd0);
    rd(8, v); chk("R12 raw untouched", v, 32'h0);
    wr(11, 32'hFFFF_FFFF);
    chk("R12 ro 11 no cfg", 32'(cfg_changed), 32'd0);

    finish_run();
  end
endmodule